// File: doc/BRIEF.md
# One-Address Accumulator Processor Core

This block is a compact processor built around a single accumulator. Every arithmetic or transfer instruction names one memory address. The accumulator supplies the other operand and receives the result. Intermediate results cannot be kept anywhere else, so a program spills them to scratch locations with a store and reads them back with a load. Each instruction word is 20 bits wide. Data words are 16-bit integers.

Instructions come from a synchronous instruction memory and operands from a synchronous data memory. Both memories sit outside the block and return their read data in the cycle after the request. The controller steps through three named states:

- `ST_FETCH` requests the instruction at the program counter.
- `ST_EXEC` decodes the returned word, issues at most one data access and advances the program counter.
- `ST_HALT` is final and is left only by reset.

The named transitions are:

- fetch-to-exec, taken always.
- exec-to-fetch, for the five memory instructions.
- exec-to-halt, for the halt opcode or an undefined opcode.
- halt-to-halt.

A value loaded or computed in `ST_EXEC` returns from memory one cycle later. It is written into the accumulator at the end of the following `ST_FETCH` cycle, overlapping the next instruction fetch. A saturating counter records every data memory access.

Top module: `accum_core`

## Requirements
- R1: While reset is asserted and right after it, the accumulator, the access counter, `halted` and `illegal` are zero, and the instruction request is made at address 0.
- R2: An instruction word holds the opcode in bits 19:15 and the data address in bits 14:0. The opcode values are load=0, store=1, add=2, sub=3, mul=4 and halt=31.
- R3: Load copies the addressed word into the accumulator. Store writes the accumulator to the addressed word, and the stored value includes a load or arithmetic result from the instruction just before it.
- R4: Add, sub and mul take the accumulator as first operand and the addressed word as second operand, and their results wrap modulo 2^16. Sub gives accumulator minus operand, and mul keeps the low 16 bits of the product.
- R5: Each instruction takes exactly two cycles, one to fetch and one to execute. A program of k memory instructions followed by halt reaches `halted` 2k+2 clock edges after reset is released.
- R6: The ten-instruction sequence load a, mul b, add c, store t1, load d, mul e, store t2, load t1, sub t2, store a leaves a*b+c-d*e at address a and a count of 10.
- R7: The access counter rises by exactly one for each data read or write, never on any other cycle, and holds at all ones once it gets there.
- R8: After halt there are no further instruction or data requests, the accumulator and counter hold, `illegal` stays 0 and `halted` stays 1 until reset.
- R9: Any opcode other than the six defined ones stops the core. It sets `illegal` together with `halted`, makes no data access and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Instruction address (program counter) |
| imem_rd | output | 1 | Instruction read request |
| imem_rdata | input | 20 | Instruction word, valid the cycle after the request |
| dmem_addr | output | ADDR_W | Data memory address |
| dmem_rd | output | 1 | Data read request |
| dmem_wr | output | 1 | Data write request |
| dmem_wdata | output | DATA_W | Data to write (accumulator value) |
| dmem_rdata | input | DATA_W | Data read result, valid the cycle after the request |
| acc_out | output | DATA_W | Current accumulator |
| ref_count | output | CNT_W | Saturating count of data memory accesses |
| halted | output | 1 | Core is in the halt state |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
Two things share one cycle in this core. The accumulator writeback of a load or arithmetic result lands in the `ST_FETCH` cycle of the next instruction. When that next instruction is a store, its write uses the accumulator on the very next edge. The bench provokes this by placing a store directly after a load and after an add, and it judges the result by the word that reaches data memory. A stale value there would expose a writeback that was late or misordered. The same overlap is exercised when halt follows a load: the final accumulator value must still appear after the core has stopped.

// File: rtl/accum_pkg.sv
package accum_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 5'd0,
        OP_STORE = 5'd1,
        OP_ADD   = 5'd2,
        OP_SUB   = 5'd3,
        OP_MUL   = 5'd4,
        OP_HALT  = 5'd31
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2,
        ALU_MUL  = 2'd3
    } alu_op_e;

endpackage

// File: rtl/accum_alu.sv
module accum_alu
    import accum_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o
);

    // All results are truncated to DATA_W bits: natural modular wrap.
    always_comb begin
        unique case (op_i)
            ALU_PASS: res_o = opnd_i;
            ALU_ADD:  res_o = acc_i + opnd_i;
            ALU_SUB:  res_o = acc_i - opnd_i;
            ALU_MUL:  res_o = acc_i * opnd_i;
            default:  res_o = opnd_i;
        endcase
    end

endmodule

// File: rtl/accum_refcnt.sv
module accum_refcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (hit_i && (count_o != CNT_MAX)) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
    import accum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc_i,
    output logic             imem_rd_o,
    output logic             dmem_rd_o,
    output logic             dmem_wr_o,
    output logic             pc_adv_o,
    output logic             wb_req_o,
    output alu_op_e          alu_sel_o,
    output logic             halted_o,
    output logic             illegal_o
);

    state_e state_q;
    state_e state_d;
    logic   bad_opc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Undefined opcode detection, used only in ST_EXEC
    always_comb begin
        unique case (opc_i)
            OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_MUL, OP_HALT: bad_opc = 1'b0;
            default: bad_opc = 1'b1;
        endcase
    end

    // Transitions: fetch-to-exec, exec-to-fetch, exec-to-halt, halt-to-halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                if (bad_opc || (opc_i == OP_HALT)) begin
                    state_d = ST_HALT;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // Outputs per state
    always_comb begin
        imem_rd_o = 1'b0;
        dmem_rd_o = 1'b0;
        dmem_wr_o = 1'b0;
        pc_adv_o  = 1'b0;
        wb_req_o  = 1'b0;
        alu_sel_o = ALU_PASS;
        unique case (state_q)
            ST_FETCH: imem_rd_o = 1'b1;
            ST_EXEC: begin
                unique case (opc_i)
                    OP_LOAD: begin
                        dmem_rd_o = 1'b1;
                        wb_req_o  = 1'b1;
                        alu_sel_o = ALU_PASS;
                        pc_adv_o  = 1'b1;
                    end
                    OP_ADD: begin
                        dmem_rd_o = 1'b1;
                        wb_req_o  = 1'b1;
                        alu_sel_o = ALU_ADD;
                        pc_adv_o  = 1'b1;
                    end
                    OP_SUB: begin
                        dmem_rd_o = 1'b1;
                        wb_req_o  = 1'b1;
                        alu_sel_o = ALU_SUB;
                        pc_adv_o  = 1'b1;
                    end
                    OP_MUL: begin
                        dmem_rd_o = 1'b1;
                        wb_req_o  = 1'b1;
                        alu_sel_o = ALU_MUL;
                        pc_adv_o  = 1'b1;
                    end
                    OP_STORE: begin
                        dmem_wr_o = 1'b1;
                        pc_adv_o  = 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
            ST_HALT: begin
            end
            default: begin
            end
        endcase
    end

    assign halted_o = (state_q == ST_HALT);

    // Sticky illegal-instruction flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
        end else if ((state_q == ST_EXEC) && bad_opc) begin
            illegal_o <= 1'b1;
        end
    end

endmodule

// File: rtl/accum_core.sv
module accum_core
    import accum_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [PC_W-1:0]         imem_addr,
    output logic                    imem_rd,
    input  logic [OPC_W+ADDR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]       dmem_addr,
    output logic                    dmem_rd,
    output logic                    dmem_wr,
    output logic [DATA_W-1:0]       dmem_wdata,
    input  logic [DATA_W-1:0]       dmem_rdata,
    output logic [DATA_W-1:0]       acc_out,
    output logic [CNT_W-1:0]        ref_count,
    output logic                    halted,
    output logic                    illegal
);

    localparam int INSN_W = OPC_W + ADDR_W;

    logic [OPC_W-1:0]  opc;
    logic              pc_adv;
    logic              wb_req;
    alu_op_e           alu_sel;
    logic [PC_W-1:0]   pc_q;
    logic              wb_pend_q;
    alu_op_e           wb_op_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_res;

    // Instruction field split
    assign opc       = imem_rdata[INSN_W-1:ADDR_W];
    assign dmem_addr = imem_rdata[ADDR_W-1:0];

    accum_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opc_i     (opc),
        .imem_rd_o (imem_rd),
        .dmem_rd_o (dmem_rd),
        .dmem_wr_o (dmem_wr),
        .pc_adv_o  (pc_adv),
        .wb_req_o  (wb_req),
        .alu_sel_o (alu_sel),
        .halted_o  (halted),
        .illegal_o (illegal)
    );

    // Program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_adv) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Pending writeback: data returns the cycle after the read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_pend_q <= 1'b0;
            wb_op_q   <= ALU_PASS;
        end else begin
            wb_pend_q <= wb_req;
            wb_op_q   <= alu_sel;
        end
    end

    accum_alu #(.DATA_W(DATA_W)) u_alu (
        .acc_i  (acc_q),
        .opnd_i (dmem_rdata),
        .op_i   (wb_op_q),
        .res_o  (alu_res)
    );

    // Accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (wb_pend_q) begin
            acc_q <= alu_res;
        end
    end

    accum_refcnt #(.CNT_W(CNT_W)) u_refcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (dmem_rd | dmem_wr),
        .count_o (ref_count)
    );

    assign imem_addr  = pc_q;
    assign dmem_wdata = acc_q;
    assign acc_out    = acc_q;

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              imem_rd,
    input logic              dmem_rd,
    input logic              dmem_wr,
    input logic              halted,
    input logic              illegal,
    input logic [DATA_W-1:0] acc_out,
    input logic [CNT_W-1:0]  ref_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_ONE_DATA_REF: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr)); // R5

    AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        imem_rd |=> !imem_rd); // R5

    AST_CNT_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ((dmem_rd || dmem_wr) && (ref_count != CNT_MAX)) |=> (ref_count == $past(ref_count) + 1'b1)); // R7

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd || dmem_wr) |=> $stable(ref_count)); // R7

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_count == CNT_MAX) |=> (ref_count == CNT_MAX)); // R7

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!imem_rd && !dmem_rd && !dmem_wr)); // R8

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8

    AST_HALT_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |=> $stable(acc_out)); // R8

    AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted); // R9

endmodule

bind accum_core accum_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_rd   (imem_rd),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .halted    (halted),
    .illegal   (illegal),
    .acc_out   (acc_out),
    .ref_count (ref_count)
);

// File: tb/test_accum_core.sv
module test_accum_core;

    localparam int PC_W   = 8;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    logic              imem_rd;
    logic [19:0]       imem_q = '0;
    logic [ADDR_W-1:0] dmem_addr;
    logic              dmem_rd;
    logic              dmem_wr;
    logic [DATA_W-1:0] dmem_wdata;
    logic [DATA_W-1:0] dmem_q = '0;
    logic [DATA_W-1:0] acc_out;
    logic [CNT_W-1:0]  ref_count;
    logic              halted;
    logic              illegal;

    logic [19:0]       prog [256];
    logic [15:0]       dmem [256];

    int n_chk  = 0;
    int n_fail = 0;
    int run_cycles = 0;

    always #10 clk = ~clk;

    accum_core #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_accum_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rd    (imem_rd),
        .imem_rdata (imem_q),
        .dmem_addr  (dmem_addr),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_q),
        .acc_out    (acc_out),
        .ref_count  (ref_count),
        .halted     (halted),
        .illegal    (illegal)
    );

    // Synchronous memories, one-cycle read latency
    always @(posedge clk) begin
        if (imem_rd) imem_q <= prog[imem_addr];
        if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;
        if (dmem_rd) dmem_q <= dmem[dmem_addr[7:0]];
    end

    function automatic logic [19:0] ins(input logic [4:0] op, input logic [14:0] a);
        return {op, a};
    endfunction

    localparam logic [4:0] LD = 5'd0, ST = 5'd1, AD = 5'd2, SB = 5'd3, ML = 5'd4, HL = 5'd31;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            prog[i] = ins(HL, 15'd0);
            dmem[i] = 16'h0000;
        end
    endtask

    // Release reset and run until halted; records edges taken
    task automatic run();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_cycles = 0;
        while (!halted && run_cycles < 2000) begin
            @(negedge clk);
            run_cycles++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_all();
        repeat (2) @(negedge clk);
        chk("R1 acc", acc_out, 0);
        chk("R1 count", ref_count, 0);
        chk("R1 halted", halted, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 fetch addr", imem_addr, 0);
        chk("R1 fetch req", imem_rd, 1);
    endtask

    task automatic t_expr();
        clear_all();
        dmem[10] = 16'd7; dmem[11] = 16'd6; dmem[12] = 16'd100;
        dmem[13] = 16'd3; dmem[14] = 16'd50;
        prog[0] = ins(LD, 15'd10); prog[1] = ins(ML, 15'd11);
        prog[2] = ins(AD, 15'd12); prog[3] = ins(ST, 15'd20);
        prog[4] = ins(LD, 15'd13); prog[5] = ins(ML, 15'd14);
        prog[6] = ins(ST, 15'd21); prog[7] = ins(LD, 15'd20);
        prog[8] = ins(SB, 15'd21); prog[9] = ins(ST, 15'd10);
        prog[10] = ins(HL, 15'd0);
        run();
        chk("R6 result", dmem[10], 16'hFFF8);   // 42+100-150 = -8
        chk("R6 t1", dmem[20], 16'd142);
        chk("R6 t2", dmem[21], 16'd150);
        chk("R6 count", ref_count, 10);
        chk("R5 cycles", run_cycles, 22);
        chk("R8 illegal low", illegal, 0);
    endtask

    task automatic t_wrap();
        clear_all();
        dmem[1] = 16'hFFFF; dmem[2] = 16'd2; dmem[3] = 16'h1234;
        dmem[4] = 16'h0100; dmem[5] = 16'd0; dmem[6] = 16'd1;
        prog[0] = ins(LD, 15'd1); prog[1] = ins(AD, 15'd2); prog[2] = ins(ST, 15'd30);
        prog[3] = ins(LD, 15'd3); prog[4] = ins(ML, 15'd4); prog[5] = ins(ST, 15'd31);
        prog[6] = ins(LD, 15'd5); prog[7] = ins(SB, 15'd6); prog[8] = ins(ST, 15'd32);
        prog[9] = ins(LD, 15'd1); prog[10] = ins(ML, 15'd1); prog[11] = ins(ST, 15'd33);
        prog[12] = ins(HL, 15'd0);
        run();
        chk("R4 add wrap", dmem[30], 16'h0001);
        chk("R4 mul low", dmem[31], 16'h3400);
        chk("R4 sub order", dmem[32], 16'hFFFF);
        chk("R4 mul ffff", dmem[33], 16'h0001);
        chk("R2 count", ref_count, 12);
    endtask

    // Writeback of a load/add coincides with the next fetch; store must see it
    task automatic t_overlap();
        clear_all();
        dmem[40] = 16'h1111;
        prog[0] = ins(LD, 15'd40); prog[1] = ins(ST, 15'd41);
        prog[2] = ins(AD, 15'd40); prog[3] = ins(ST, 15'd42);
        prog[4] = ins(LD, 15'd40);
        prog[5] = ins(HL, 15'd0);
        run();
        chk("R3 store after load", dmem[41], 16'h1111);
        chk("R3 store after add", dmem[42], 16'h2222);
        chk("R3 load before halt", acc_out, 16'h1111);
    endtask

    task automatic t_halt();
        clear_all();
        dmem[50] = 16'd5;
        prog[0] = ins(LD, 15'd50); prog[1] = ins(HL, 15'd0);
        prog[2] = ins(ST, 15'd51); prog[3] = ins(LD, 15'd52);
        run();
        chk("R8 halted", halted, 1);
        chk("R8 no later store", dmem[51], 16'd0);
        chk("R8 acc", acc_out, 16'd5);
        chk("R8 count", ref_count, 1);
        chk("R8 illegal", illegal, 0);
        chk("R8 no fetch", imem_rd, 0);
    endtask

    task automatic t_illegal(input logic [4:0] bad);
        clear_all();
        dmem[60] = 16'd9;
        prog[0] = ins(LD, 15'd60); prog[1] = ins(bad, 15'd61);
        prog[2] = ins(ST, 15'd62);
        run();
        chk("R9 halted", halted, 1);
        chk("R9 illegal", illegal, 1);
        chk("R9 count", ref_count, 1);
        chk("R9 no access", dmem[61], 16'd0);
        chk("R9 no later store", dmem[62], 16'd0);
        chk("R9 acc", acc_out, 16'd9);
    endtask

    task automatic t_saturate();
        clear_all();
        for (int i = 0; i < 70; i++) prog[i] = ins(LD, 15'd70);
        prog[70] = ins(HL, 15'd0);
        run();
        chk("R7 saturated", ref_count, 63);
        chk("R5 long cycles", run_cycles, 142);
    endtask

    initial begin
        t_reset();
        t_expr();
        t_wrap();
        t_overlap();
        t_halt();
        t_illegal(5'd5);
        t_illegal(5'd30);
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule